// File: doc/BRIEF.md
# Masked Interrupt Event Aggregator

This block gathers the interrupt events of a network controller into one 32-bit event register, gates them with a 32-bit mask register and drives 13 separate level interrupt lines. Engines inside the controller raise an event by pulsing the matching bit of a set vector for one cycle. Software acknowledges events by writing the event register: each 1 in the written word clears that event bit. The mask register is an ordinary read/write register.

Thirteen event bits are implemented, at positions 31 down to 19. Each interrupt line is tied to one of them through a fixed, non-monotonic mapping. A line is high while its event bit and the mask bit at the same position are both set. The line outputs come from flops, so a line follows a register change one cycle later. Bus decode beyond the two registers is not part of the block, and neither is any priority between lines.

Top module: `irq_event_agg`

## Requirements
- R1: Only event bits 31 to 19 are implemented. Bits 18 to 0 of the event register always read 0, and set pulses on those positions have no effect.
- R2: A write with `wr_sel_i`=0 is a write to the event register. From the next cycle on, every event bit that is 1 in `wr_data_i` is 0, and every bit written as 0 keeps its value.
- R3: If a set pulse and a clearing write hit the same event bit in the same cycle, the bit is 1 afterwards.
- R4: With no set pulse and no event write, the event register holds its value.
- R5: A write with `wr_sel_i`=1 stores all 32 bits of `wr_data_i` in the mask register. A read with `rd_sel_i`=1 returns the mask, and a read with `rd_sel_i`=0 returns the event register. Reads are combinational.
- R6: Line i is high exactly when, in the previous cycle, the event bit mapped to line i and the mask bit at the same position were both 1. An output therefore lags its register change by one cycle.
- R7: Lines 0 to 12 map to event bits 27, 26, 19, 20, 25, 24, 23, 21, 31, 28, 22, 29 and 30, in that order.
- R8: Reset, active low and asynchronous, clears the event register and the mask register and drives all lines low.
- R9: An event write leaves the mask register unchanged, and a mask write leaves the event register unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| set_i | input | 32 | One-cycle set pulses, one per event bit position |
| wr_en_i | input | 1 | Register write strobe |
| wr_sel_i | input | 1 | Write target: 0 selects the event register, 1 selects the mask register |
| wr_data_i | input | 32 | Write data. For the event register, a 1 clears the bit |
| rd_sel_i | input | 1 | Read source: 0 selects the event register, 1 selects the mask register |
| rd_data_o | output | 32 | Read data of the selected register |
| irq_o | output | 13 | Interrupt lines, one per mapped event |

## Verification
The bench walks a single event through every line in turn. A design with two lines swapped in the mapping raises a neighbour's line and fails the one-hot comparison. Set pulses on the unimplemented low bits would show up as nonzero low bits on readback. A clearing write that lands in the same cycle as a set of the same bit must leave the bit at 1; a design that gives the clear priority would drop that event. A cycle-by-cycle scoreboard checks the outputs, so a line that reacts in the same cycle, or two cycles late, is caught, and so is a mask or event write that disturbs the other register.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;

  localparam int unsigned REG_W     = 32;
  localparam int unsigned NUM_LINES = 13;
  localparam int unsigned BIT_IDX_W = $clog2(REG_W);

  // Implemented event positions: bits 31..19
  localparam logic [REG_W-1:0] EVT_IMPL = 32'hFFF8_0000;

  // Register select encodings
  typedef enum logic {
    SEL_EVENT = 1'b0,
    SEL_MASK  = 1'b1
  } reg_sel_e;

  // Fixed line -> event bit position mapping
  function automatic logic [BIT_IDX_W-1:0] line_bit(input int unsigned line);
    logic [BIT_IDX_W-1:0] pos;
    case (line)
      0:       pos = 5'd27; // tx frame done
      1:       pos = 5'd26; // tx buffer done
      2:       pos = 5'd19; // tx underrun
      3:       pos = 5'd20; // retry limit
      4:       pos = 5'd25; // rx frame done
      5:       pos = 5'd24; // rx buffer done
      6:       pos = 5'd23; // management transfer done
      7:       pos = 5'd21; // late collision
      8:       pos = 5'd31; // heartbeat
      9:       pos = 5'd28; // graceful stop
      10:      pos = 5'd22; // bus error
      11:      pos = 5'd29; // babbling transmit
      default: pos = 5'd30; // babbling receive
    endcase
    return pos;
  endfunction

  // Next event value: clears first, then sets, so a set wins
  function automatic logic [REG_W-1:0] evt_next(input logic [REG_W-1:0] cur,
                                                input logic [REG_W-1:0] clr,
                                                input logic [REG_W-1:0] set);
    return ((cur & ~clr) | set) & EVT_IMPL;
  endfunction

endpackage

// File: rtl/irq_evt_reg.sv
module irq_evt_reg
  import irq_agg_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [REG_W-1:0] set_i,
  input  logic             clr_en_i,
  input  logic [REG_W-1:0] clr_data_i,
  output logic [REG_W-1:0] evt_o
);

  logic [REG_W-1:0] evt_q;
  logic [REG_W-1:0] clr_vec;
  logic [REG_W-1:0] set_vec;
  logic             any_set;

  assign clr_vec = clr_en_i ? clr_data_i : '0;
  assign set_vec = set_i & EVT_IMPL;
  assign any_set = |set_vec;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) evt_q <= '0;
    else         evt_q <= evt_next(evt_q, clr_vec, set_i);
  end

  assign evt_o = evt_q;

  AST_SET_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    any_set |=> ((evt_q & $past(set_vec)) == $past(set_vec))); // R3

  AST_W1C_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_en_i |=> ((evt_q & $past(clr_data_i & ~set_vec)) == '0)); // R2

  AST_EVT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_en_i && !any_set) |=> $stable(evt_q)); // R4

  AST_LOW_BITS_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (evt_q & ~EVT_IMPL) == '0); // R1

endmodule

// File: rtl/irq_mask_reg.sv
module irq_mask_reg
  import irq_agg_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_i,
  input  logic [REG_W-1:0] wr_data_i,
  output logic [REG_W-1:0] mask_o
);

  logic [REG_W-1:0] mask_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   mask_q <= '0;
    else if (wr_i) mask_q <= wr_data_i;
  end

  assign mask_o = mask_q;

  AST_MASK_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_i |=> $stable(mask_q)); // R9

  AST_MASK_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i |=> (mask_q == $past(wr_data_i))); // R5

endmodule

// File: rtl/irq_line_map.sv
module irq_line_map
  import irq_agg_pkg::*;
(
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [REG_W-1:0]     evt_i,
  input  logic [REG_W-1:0]     mask_i,
  output logic [NUM_LINES-1:0] irq_o
);

  logic [REG_W-1:0]     active;
  logic [NUM_LINES-1:0] line_active;
  logic [NUM_LINES-1:0] irq_q;

  assign active = evt_i & mask_i;

  for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
    localparam logic [BIT_IDX_W-1:0] POS = line_bit(g);
    assign line_active[g] = active[POS];

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) irq_q[g] <= 1'b0;
      else         irq_q[g] <= line_active[g];
    end

    AST_LINE_RISE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(irq_q[g]) |-> $past(evt_i[POS] && mask_i[POS])); // R6
  end

  assign irq_o = irq_q;

  AST_QUIET_LINES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active == '0) |=> (irq_q == '0)); // R6

endmodule

// File: rtl/irq_event_agg.sv
module irq_event_agg
  import irq_agg_pkg::*;
(
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [REG_W-1:0]     set_i,
  input  logic                 wr_en_i,
  input  logic                 wr_sel_i,
  input  logic [REG_W-1:0]     wr_data_i,
  input  logic                 rd_sel_i,
  output logic [REG_W-1:0]     rd_data_o,
  output logic [NUM_LINES-1:0] irq_o
);

  logic             evt_wr;
  logic             mask_wr;
  logic [REG_W-1:0] evt_val;
  logic [REG_W-1:0] mask_val;

  assign evt_wr  = wr_en_i && (reg_sel_e'(wr_sel_i) == SEL_EVENT);
  assign mask_wr = wr_en_i && (reg_sel_e'(wr_sel_i) == SEL_MASK);

  irq_evt_reg u_evt (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .set_i      (set_i),
    .clr_en_i   (evt_wr),
    .clr_data_i (wr_data_i),
    .evt_o      (evt_val)
  );

  irq_mask_reg u_mask (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_i      (mask_wr),
    .wr_data_i (wr_data_i),
    .mask_o    (mask_val)
  );

  irq_line_map u_map (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .evt_i  (evt_val),
    .mask_i (mask_val),
    .irq_o  (irq_o)
  );

  assign rd_data_o = (reg_sel_e'(rd_sel_i) == SEL_MASK) ? mask_val : evt_val;

  AST_EVT_WR_KEEPS_MASK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evt_wr |=> $stable(mask_val)); // R9

  AST_RESET_LINES_LOW: assert property (@(posedge clk_i)
    !rst_ni |-> (irq_o == '0)); // R8

endmodule

// File: tb/irq_event_agg_tb.sv
module irq_event_agg_tb;

  localparam int CLK_PERIOD = 10;
  localparam int NL = 13;
  localparam int LMAP [NL] = '{27, 26, 19, 20, 25, 24, 23, 21, 31, 28, 22, 29, 30};

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] set_v = '0;
  logic        wr_en = 1'b0;
  logic        wr_sel = 1'b0;
  logic [31:0] wr_data = '0;
  logic        rd_sel = 1'b0;
  logic [31:0] rd_data;
  logic [12:0] irq;

  irq_event_agg u_dut (
    .clk_i(clk), .rst_ni(rst_n), .set_i(set_v), .wr_en_i(wr_en),
    .wr_sel_i(wr_sel), .wr_data_i(wr_data), .rd_sel_i(rd_sel),
    .rd_data_o(rd_data), .irq_o(irq)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  bit done   = 0;

  always @(posedge clk) cyc <= cyc + 1;

  typedef struct {
    int          due;
    logic [12:0] irq;
    string       req;
  } exp_t;
  exp_t exp_q[$];

  logic [31:0] m_evt = '0;
  logic [31:0] m_mask = '0;

  function automatic logic [12:0] model_irq(input logic [31:0] e, input logic [31:0] m);
    logic [12:0] r;
    for (int i = 0; i < NL; i++) r[i] = e[LMAP[i]] & m[LMAP[i]];
    return r;
  endfunction

  task automatic check32(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Monitor: compare line outputs against queued expectations
  initial begin
    forever begin
      @(negedge clk);
      while (exp_q.size() > 0 && exp_q[0].due <= cyc) begin
        exp_t it;
        it = exp_q.pop_front();
        checks++;
        if (irq !== it.irq) begin
          fails++;
          $display("FAIL %s lines actual=%h expected=%h (cycle %0d)", it.req, irq, it.irq, cyc);
        end
      end
    end
  end

  // Driver: one cycle of stimulus, model update, expectation push, readback
  task automatic step(input string req, input logic [31:0] s, input logic we,
                      input logic sel, input logic [31:0] d);
    @(negedge clk);
    set_v = s; wr_en = we; wr_sel = sel; wr_data = d;
    @(posedge clk);
    #1;
    set_v = '0; wr_en = 1'b0; wr_data = '0;
    if (we && !sel) m_evt = m_evt & ~d;
    if (we && sel)  m_mask = d;
    m_evt = (m_evt | s) & 32'hFFF8_0000;
    exp_q.push_back('{due: cyc + 1, irq: model_irq(m_evt, m_mask), req: req});
    rd_sel = 1'b0; #1;
    check32({req, " event readback"}, rd_data, m_evt);
    rd_sel = 1'b1; #1;
    check32({req, " mask readback"}, rd_data, m_mask);
  endtask

  task automatic drain();
    while (exp_q.size() > 0) @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 50000);
    fails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    // R8: reset state
    #(CLK_PERIOD * 2 + 2);
    check32("R8 lines in reset", {19'b0, irq}, '0);
    rd_sel = 1'b0; #1; check32("R8 event in reset", rd_data, '0);
    rd_sel = 1'b1; #1; check32("R8 mask in reset", rd_data, '0);
    @(negedge clk); rst_n = 1'b1;

    // R5: mask write and readback
    step("R5 mask all ones", '0, 1'b1, 1'b1, 32'hFFFF_FFFF);

    // R7 / R6: walk one event through every line, then clear it (R2)
    for (int i = 0; i < NL; i++) begin
      step("R7 single event maps to line", 32'h1 << LMAP[i], 1'b0, 1'b0, '0);
      step("R6 line held one cycle", '0, 1'b0, 1'b0, '0);
      step("R2 clear single event", '0, 1'b1, 1'b0, 32'h1 << LMAP[i]);
    end

    // R1: set every position, low bits must stay 0
    step("R1 set all positions", 32'hFFFF_FFFF, 1'b0, 1'b0, '0);
    // R4: idle hold
    step("R4 idle hold", '0, 1'b0, 1'b0, '0);
    step("R4 idle hold again", '0, 1'b0, 1'b0, '0);
    // R2: partial clear
    step("R2 partial clear", '0, 1'b1, 1'b0, 32'h0A00_0000);
    // R3: same-cycle set and clear
    step("R3 set beats clear", 32'h8000_0000, 1'b1, 1'b0, 32'h8000_0000);
    step("R3 set beats clear mixed", 32'h0200_0000, 1'b1, 1'b0, 32'h0280_0000);
    // R9: mask write leaves events alone, lines drop
    step("R9 mask cleared", '0, 1'b1, 1'b1, 32'h0000_0000);
    step("R6 lines low with zero mask", '0, 1'b0, 1'b0, '0);
    step("R6 partial mask", '0, 1'b1, 1'b1, 32'hA5A5_5A5A);
    step("R9 event write keeps mask", '0, 1'b1, 1'b0, 32'h3000_0000);
    step("R6 set under mask", 32'h0008_0000, 1'b0, 1'b0, '0);
    step("R1 low bit pulses ignored", 32'h0007_FFFF, 1'b0, 1'b0, '0);
    step("R2 clear everything", '0, 1'b1, 1'b0, 32'hFFFF_FFFF);
    step("R4 idle after clear", '0, 1'b0, 1'b0, '0);
    step("R6 rebuild state", 32'hFFF8_0000, 1'b1, 1'b1, 32'hFFFF_FFFF);
    step("R6 settle", '0, 1'b0, 1'b0, '0);
    drain();

    // R8: reset during activity
    @(negedge clk); rst_n = 1'b0;
    #2;
    check32("R8 lines after midrun reset", {19'b0, irq}, '0);
    rd_sel = 1'b0; #1; check32("R8 event after midrun reset", rd_data, '0);
    rd_sel = 1'b1; #1; check32("R8 mask after midrun reset", rd_data, '0);
    m_evt = '0; m_mask = '0;
    @(negedge clk); rst_n = 1'b1;
    step("R8 quiet after reset", '0, 1'b0, 1'b0, '0);
    drain();
    @(negedge clk);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule